// File: doc/BRIEF.md
# BCD Calendar Real-Time Clock with Alarm

This block keeps wall-clock time and date as packed BCD bytes (seconds, minutes, hours, day of month, month, two-digit year and a day-of-week count). It advances one second per pulse on its one-second tick input, but only while software has switched it to counting. Software reaches it through a byte-wide register bus with an address, write data, a write strobe and a read strobe. Time reads come from a shadow copy that is refreshed only on request, so a burst of reads across several bytes always describes one instant.

A set of alarm bytes is compared with the calendar on every advance. Sticky status flags record each second, minute, hour and day rollover, the alarm match and a power-up event. One level interrupt output combines the alarm flag and one selectable periodic flag under an enable register.

A two-state run controller holds the counting state. It starts in RUN_HALTED. The transition START (a control write with bit 0 = 1) moves it to RUN_COUNTING, and the transition HALT (a control write with bit 0 = 0) returns it to RUN_HALTED. Any other control write leaves the state unchanged.

Top module: `bcd_rtc`

## Requirements
- R1: After reset the seconds, minutes, hours, year and week read 0x00, the day and month read 0x01, status (0x0E) reads 0x80, control (0x0D) and interrupt enable (0x0F) read 0x00, and irq is low.
- R2: Each counted tick adds one second in packed BCD. Seconds wrap 0x59 to 0x00 and carry into minutes, which wrap 0x59 to 0x00 and carry into hours. Hours wrap 0x23 to 0x00 and carry into the day and into the week (0..6, 6 wraps to 0). Past the month's last day the day becomes 0x01 and the month advances. Month 0x12 wraps to 0x01 and carries into the year, and year 0x99 wraps to 0x00. Registers 0x00..0x06 hold seconds, minutes, hours, day, month, year and week, in that order.
- R3: The counters advance on a tick only while control bit 0 (the run bit) is 1. Control bit 0 and status bit 1 read back the run state, and while it is 0 the time stays frozen.
- R4: Reads of 0x00..0x06 return a shadow copy. Writing control with bit 6 = 1 loads the shadow with the live time as it stood before that edge. Control bit 6 always reads 0.
- R5: Writing 0x00..0x06 loads the live counter field. The alarm bytes at 0x07..0x0C (seconds, minutes, hours, day, month, year) and the storage bytes at 0x10 and 0x11 read back what was written. Any unmapped address reads 0x00.
- R6: Status bit 6 (alarm) sets on a counted tick whose resulting seconds through year all equal the alarm bytes. The week is not compared. Once set, the flag stays set until it is cleared.
- R7: Writing 1 to status bits 2..7 clears them and writing 0 leaves them unchanged. A set and a clear in the same cycle leave the flag set. The power-up flag (bit 7) is set only by reset.
- R8: Status bit 2 sets on every counted tick, bit 3 when seconds wrap, bit 4 when minutes wrap as well, and bit 5 when hours wrap 0x23 to 0x00. All four are sticky.
- R9: irq is high while (enable bit 3 and status bit 6) or (enable bit 2 and the periodic flag chosen by enable bits [1:0]) holds. The selection is 00 second, 01 minute, 10 hour and 11 day. irq falls only after a status clear or an enable write.
- R10: A read strobe at a clock edge loads bus_rdata with the addressed value from before that edge. Without a strobe, bus_rdata holds its value.
- R11: February has 0x29 days when the BCD year is divisible by 4, and 0x28 days otherwise. April, June, September and November have 0x30 days, and the other months have 0x31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1s | input | 1 | One-cycle pulse per second |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Level interrupt |

## Verification
On every cycle the assertions check four things: the time stays frozen while the controller is halted, the seconds and month fields stay in their BCD ranges, the shadow changes only on a snapshot request and then equals the previous live time, and the sticky alarm and power-up flags and the irq line fall only under the writes allowed to clear them. Only the bench scenarios can show the calendar carries through month ends, leap and non-leap Februaries and the year wrap. The same holds for the alarm landing on the exact matching second, the periodic selection choosing the right rollover, and the read data matching a reference model cycle by cycle.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    localparam int BYTE_W  = 8;
    localparam int NF      = 7;   // calendar fields
    localparam int NA      = 6;   // alarm fields (no week)
    localparam int NEV     = 4;   // periodic event kinds

    localparam int F_SEC = 0;
    localparam int F_MIN = 1;
    localparam int F_HR  = 2;
    localparam int F_DAY = 3;
    localparam int F_MON = 4;
    localparam int F_YR  = 5;
    localparam int F_WK  = 6;

    typedef logic [NF-1:0][BYTE_W-1:0] rtc_vec_t;
    typedef logic [NA-1:0][BYTE_W-1:0] alarm_vec_t;

    typedef enum logic [0:0] {
        RUN_HALTED   = 1'b0,
        RUN_COUNTING = 1'b1
    } run_state_t;

    localparam rtc_vec_t TIME_RESET = {8'h00, 8'h00, 8'h01, 8'h01, 8'h00, 8'h00, 8'h00};

    function automatic logic [BYTE_W-1:0] bcd_inc(input logic [BYTE_W-1:0] v);
        if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic leap_bcd(input logic [BYTE_W-1:0] yr);
        logic [3:0] o;
        o = yr[3:0];
        if (!yr[4])
            return (o == 4'd0) || (o == 4'd4) || (o == 4'd8);
        else
            return (o == 4'd2) || (o == 4'd6);
    endfunction

    function automatic logic [BYTE_W-1:0] last_day(input logic [BYTE_W-1:0] mon,
                                                   input logic [BYTE_W-1:0] yr);
        case (mon)
            8'h02:                      return leap_bcd(yr) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
    import rtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 advance,
    input  logic [NF-1:0]        wr_sel,
    input  logic [BYTE_W-1:0]    wr_data,
    output rtc_vec_t             live,
    output rtc_vec_t             next_tm,
    output logic [NEV-1:0]       ev
);
    rtc_vec_t cur_q;
    rtc_vec_t nxt_c;

    always_comb begin
        nxt_c = cur_q;
        ev    = '0;
        if (advance) begin
            ev[0] = 1'b1;
            if (cur_q[F_SEC] == 8'h59) begin
                nxt_c[F_SEC] = 8'h00;
                ev[1] = 1'b1;
                if (cur_q[F_MIN] == 8'h59) begin
                    nxt_c[F_MIN] = 8'h00;
                    ev[2] = 1'b1;
                    if (cur_q[F_HR] == 8'h23) begin
                        nxt_c[F_HR] = 8'h00;
                        ev[3] = 1'b1;
                        nxt_c[F_WK] = (cur_q[F_WK] >= 8'h06) ? 8'h00 : bcd_inc(cur_q[F_WK]);
                        if (cur_q[F_DAY] >= last_day(cur_q[F_MON], cur_q[F_YR])) begin
                            nxt_c[F_DAY] = 8'h01;
                            if (cur_q[F_MON] >= 8'h12) begin
                                nxt_c[F_MON] = 8'h01;
                                nxt_c[F_YR]  = (cur_q[F_YR] == 8'h99) ? 8'h00 : bcd_inc(cur_q[F_YR]);
                            end else begin
                                nxt_c[F_MON] = bcd_inc(cur_q[F_MON]);
                            end
                        end else begin
                            nxt_c[F_DAY] = bcd_inc(cur_q[F_DAY]);
                        end
                    end else begin
                        nxt_c[F_HR] = bcd_inc(cur_q[F_HR]);
                    end
                end else begin
                    nxt_c[F_MIN] = bcd_inc(cur_q[F_MIN]);
                end
            end else begin
                nxt_c[F_SEC] = bcd_inc(cur_q[F_SEC]);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= TIME_RESET;
        end else begin
            for (int i = 0; i < NF; i++) begin
                if (wr_sel[i])
                    cur_q[i] <= wr_data;
                else
                    cur_q[i] <= nxt_c[i];
            end
        end
    end

    assign live    = cur_q;
    assign next_tm = nxt_c;
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
    import rtc_pkg::*;
(
    input  logic       advance,
    input  rtc_vec_t   next_tm,
    input  alarm_vec_t alarm,
    output logic       hit
);
    logic [NA-1:0] eq;

    for (genvar g = 0; g < NA; g++) begin : g_cmp
        assign eq[g] = (next_tm[g] == alarm[g]);
    end

    assign hit = advance && (&eq);
endmodule

// File: rtl/rtc_flag_irq.sv
module rtc_flag_irq
    import rtc_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NEV-1:0]  ev,
    input  logic            alarm_hit,
    input  logic            clr_en,
    input  logic [5:0]      clr_mask,
    input  logic [3:0]      ien,
    output logic [5:0]      flags,
    output logic            irq
);
    // flags[3:0] periodic events, flags[4] alarm, flags[5] power-up
    localparam logic [5:0] FLAGS_RESET = 6'b100000;

    logic [5:0] set_v;
    logic [5:0] clr_v;
    logic       sel_ev;

    assign set_v = {1'b0, alarm_hit, ev};
    assign clr_v = clr_en ? clr_mask : 6'b0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            flags <= FLAGS_RESET;
        else
            flags <= (flags & ~clr_v) | set_v;
    end

    always_comb begin
        unique case (ien[1:0])
            2'b00:   sel_ev = flags[0];
            2'b01:   sel_ev = flags[1];
            2'b10:   sel_ev = flags[2];
            default: sel_ev = flags[3];
        endcase
        irq = (ien[3] && flags[4]) || (ien[2] && sel_ev);
    end
endmodule

// File: rtl/rtc_run_fsm.sv
module rtc_run_fsm
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic run_bit,
    output logic running
);
    run_state_t state_q;
    run_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RUN_HALTED;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RUN_HALTED:   if (ctrl_wr && run_bit)  state_d = RUN_COUNTING; // START
            RUN_COUNTING: if (ctrl_wr && !run_bit) state_d = RUN_HALTED;   // HALT
            default:      state_d = RUN_HALTED;
        endcase
    end

    always_comb begin
        running = (state_q == RUN_COUNTING);
    end
endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 5
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_1s,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              irq
);
    localparam int A_TIME = 0;
    localparam int A_ALM  = A_TIME + NF;
    localparam int A_CTRL = A_ALM + NA;
    localparam int A_STAT = A_CTRL + 1;
    localparam int A_IEN  = A_STAT + 1;
    localparam int A_CMP0 = A_IEN + 1;
    localparam int A_CMP1 = A_CMP0 + 1;

    localparam int CTRL_RUN_BIT  = 0;
    localparam int CTRL_SNAP_BIT = 6;

    logic [NF-1:0]  time_wr_sel;
    logic [NA-1:0]  alm_wr_sel;
    logic           time_wr_any;
    logic           ctrl_wr, stat_wr, ien_wr, cmp0_wr, cmp1_wr;
    logic           snap_req;
    logic           running;
    logic           advance;
    rtc_vec_t       live_tm, next_tm, shadow_tm;
    alarm_vec_t     alarm_q;
    logic [NEV-1:0] ev;
    logic           alarm_hit;
    logic [5:0]     flags;
    logic           alarm_flag, pwrup_flag;
    logic [5:0]     ctrl_keep_q;
    logic [3:0]     ien_q;
    logic [7:0]     cmp0_q, cmp1_q;
    logic [7:0]     rd_val;

    for (genvar g = 0; g < NF; g++) begin : g_twr
        assign time_wr_sel[g] = bus_wr && (bus_addr == ADDR_W'(A_TIME + g));
    end
    for (genvar g = 0; g < NA; g++) begin : g_awr
        assign alm_wr_sel[g] = bus_wr && (bus_addr == ADDR_W'(A_ALM + g));
    end

    assign time_wr_any = |time_wr_sel;
    assign ctrl_wr  = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
    assign stat_wr  = bus_wr && (bus_addr == ADDR_W'(A_STAT));
    assign ien_wr   = bus_wr && (bus_addr == ADDR_W'(A_IEN));
    assign cmp0_wr  = bus_wr && (bus_addr == ADDR_W'(A_CMP0));
    assign cmp1_wr  = bus_wr && (bus_addr == ADDR_W'(A_CMP1));
    assign snap_req = ctrl_wr && bus_wdata[CTRL_SNAP_BIT];
    assign advance  = tick_1s && running;

    rtc_run_fsm u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (ctrl_wr),
        .run_bit (bus_wdata[CTRL_RUN_BIT]),
        .running (running)
    );

    rtc_time_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (advance),
        .wr_sel  (time_wr_sel),
        .wr_data (bus_wdata),
        .live    (live_tm),
        .next_tm (next_tm),
        .ev      (ev)
    );

    rtc_alarm_cmp u_alm (
        .advance (advance),
        .next_tm (next_tm),
        .alarm   (alarm_q),
        .hit     (alarm_hit)
    );

    rtc_flag_irq u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .ev        (ev),
        .alarm_hit (alarm_hit),
        .clr_en    (stat_wr),
        .clr_mask  (bus_wdata[7:2]),
        .ien       (ien_q),
        .flags     (flags),
        .irq       (irq)
    );

    assign alarm_flag = flags[4];
    assign pwrup_flag = flags[5];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alarm_q     <= '0;
            ctrl_keep_q <= '0;
            ien_q       <= '0;
            cmp0_q      <= '0;
            cmp1_q      <= '0;
            shadow_tm   <= TIME_RESET;
        end else begin
            for (int i = 0; i < NA; i++)
                if (alm_wr_sel[i]) alarm_q[i] <= bus_wdata;
            if (ctrl_wr)  ctrl_keep_q <= {bus_wdata[7], bus_wdata[5:1]};
            if (ien_wr)   ien_q       <= bus_wdata[3:0];
            if (cmp0_wr)  cmp0_q      <= bus_wdata;
            if (cmp1_wr)  cmp1_q      <= bus_wdata;
            if (snap_req) shadow_tm   <= live_tm;
        end
    end

    always_comb begin
        rd_val = 8'h00;
        for (int i = 0; i < NF; i++)
            if (bus_addr == ADDR_W'(A_TIME + i)) rd_val = shadow_tm[i];
        for (int i = 0; i < NA; i++)
            if (bus_addr == ADDR_W'(A_ALM + i)) rd_val = alarm_q[i];
        if (bus_addr == ADDR_W'(A_CTRL)) rd_val = {ctrl_keep_q[5], 1'b0, ctrl_keep_q[4:0], running};
        if (bus_addr == ADDR_W'(A_STAT)) rd_val = {flags, running, 1'b0};
        if (bus_addr == ADDR_W'(A_IEN))  rd_val = {4'h0, ien_q};
        if (bus_addr == ADDR_W'(A_CMP0)) rd_val = cmp0_q;
        if (bus_addr == ADDR_W'(A_CMP1)) rd_val = cmp1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bus_rdata <= 8'h00;
        else if (bus_rd)
            bus_rdata <= rd_val;
    end
endmodule

// File: rtl/rtc_checker.sv
module rtc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        running,
    input logic        time_wr_any,
    input logic [55:0] live_tm,
    input logic [55:0] shadow_tm,
    input logic        snap_req,
    input logic        stat_wr,
    input logic        ien_wr,
    input logic [7:0]  bus_wdata,
    input logic        alarm_flag,
    input logic        pwrup_flag,
    input logic        irq
);
    AST_FROZEN_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !time_wr_any) |=> $stable(live_tm)); // R3

    AST_SEC_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tm[3:0] <= 4'd9) && (live_tm[7:0] <= 8'h59)); // R2

    AST_MONTH_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (live_tm[39:32] >= 8'h01) && (live_tm[39:32] <= 8'h12)); // R2

    AST_SHADOW_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !snap_req |=> $stable(shadow_tm)); // R4

    AST_SHADOW_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
        snap_req |=> (shadow_tm == $past(live_tm))); // R4

    AST_ALARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_flag && !(stat_wr && bus_wdata[6])) |=> alarm_flag); // R6

    AST_PWRUP_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrup_flag |=> !pwrup_flag); // R7

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !stat_wr && !ien_wr) |=> irq); // R9
endmodule

bind bcd_rtc rtc_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .running     (running),
    .time_wr_any (time_wr_any),
    .live_tm     (live_tm),
    .shadow_tm   (shadow_tm),
    .snap_req    (snap_req),
    .stat_wr     (stat_wr),
    .ien_wr      (ien_wr),
    .bus_wdata   (bus_wdata),
    .alarm_flag  (alarm_flag),
    .pwrup_flag  (pwrup_flag),
    .irq         (irq)
);

// File: tb/tb_bcd_rtc.sv
module tb_bcd_rtc;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_1s = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [7:0]    bus_rdata;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    bcd_rtc #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    // ---------------- behavioural reference model ----------------
    int         ms[7];      // live time, binary
    int         sh[7];      // shadow, binary
    logic [7:0] al[6];
    bit         mrun;
    logic [7:0] mkeep;
    logic [5:0] mflags;
    logic [3:0] mien;
    logic [7:0] mc0, mc1;
    logic [7:0] mrd;

    function automatic logic [7:0] b2d(input int v);
        return 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic int d2b(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic int mdays(input int mon, input int yr);
        if (mon == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mon == 4 || mon == 6 || mon == 9 || mon == 11) return 30;
        return 31;
    endfunction

    function automatic logic [7:0] mread(input int a);
        if (a < 7)  return b2d(sh[a]);
        if (a < 13) return al[a-7];
        case (a)
            13: return mkeep | {7'b0, mrun};
            14: return {mflags, mrun, 1'b0};
            15: return {4'h0, mien};
            16: return mc0;
            17: return mc1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic bit m_irq();
        bit s;
        s = mflags[mien[1:0]];
        return (mien[3] && mflags[4]) || (mien[2] && s);
    endfunction

    always @(posedge clk) begin
        int  nt[7];
        int  old[7];
        bit  e0, e1, e2, e3, am;
        int  a;
        if (!rst_n) begin
            ms = '{0, 0, 0, 1, 1, 0, 0};
            sh = ms;
            foreach (al[i]) al[i] = 8'h00;
            mrun = 0; mkeep = 0; mflags = 6'b100000; mien = 0;
            mc0 = 0; mc1 = 0; mrd = 0;
        end else begin
            old = ms;
            a = int'(bus_addr);
            if (bus_rd) mrd = mread(a);
            nt = ms; e0 = 0; e1 = 0; e2 = 0; e3 = 0; am = 0;
            if (mrun && tick_1s) begin
                e0 = 1; nt[0] = ms[0] + 1;
                if (nt[0] == 60) begin
                    nt[0] = 0; e1 = 1; nt[1] = ms[1] + 1;
                    if (nt[1] == 60) begin
                        nt[1] = 0; e2 = 1; nt[2] = ms[2] + 1;
                        if (nt[2] == 24) begin
                            nt[2] = 0; e3 = 1; nt[6] = (ms[6] + 1) % 7;
                            nt[3] = ms[3] + 1;
                            if (nt[3] > mdays(ms[4], ms[5])) begin
                                nt[3] = 1; nt[4] = ms[4] + 1;
                                if (nt[4] > 12) begin
                                    nt[4] = 1; nt[5] = (ms[5] + 1) % 100;
                                end
                            end
                        end
                    end
                end
                am = 1;
                for (int i = 0; i < 6; i++) if (b2d(nt[i]) != al[i]) am = 0;
            end
            ms = nt;
            if (bus_wr) begin
                if (a < 7) ms[a] = d2b(bus_wdata);
                else if (a < 13) al[a-7] = bus_wdata;
                else if (a == 13) begin
                    mrun = bus_wdata[0];
                    mkeep = bus_wdata & 8'hBE;
                    if (bus_wdata[6]) sh = old;
                end
                else if (a == 14) mflags = mflags & ~bus_wdata[7:2];
                else if (a == 15) mien = bus_wdata[3:0];
                else if (a == 16) mc0 = bus_wdata;
                else if (a == 17) mc1 = bus_wdata;
            end
            mflags = mflags | {1'b0, am, e3, e2, e1, e0};
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // every-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check("R10 rdata vs model", bus_rdata, mrd);
            check("R9 irq vs model", {7'b0, irq}, {7'b0, m_irq()});
        end
    end

    task automatic wr(input int a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = AW'(a); bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_expect(input int a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        bus_addr = AW'(a); bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        check(tag, bus_rdata, exp);
    endtask

    task automatic ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick_1s = 1'b1;
            @(negedge clk); tick_1s = 1'b0;
        end
    endtask

    task automatic irq_expect(input bit exp, input string tag);
        check(tag, {7'b0, irq}, {7'b0, exp});
    endtask

    task automatic set_time(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                            input logic [7:0] d, input logic [7:0] mo, input logic [7:0] y);
        wr(13, 8'h00);
        wr(0, s); wr(1, m); wr(2, h); wr(3, d); wr(4, mo); wr(5, y);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        irq_expect(1'b0, "R1 irq after reset");
        rd_expect(0,  8'h00, "R1 seconds");
        rd_expect(3,  8'h01, "R1 day");
        rd_expect(4,  8'h01, "R1 month");
        rd_expect(14, 8'h80, "R1 status");
        rd_expect(13, 8'h00, "R1 control");
        rd_expect(15, 8'h00, "R1 int enable");

        // R7 write-zero keeps, write-one clears power-up
        wr(14, 8'h00);
        rd_expect(14, 8'h80, "R7 write 0 keeps power-up");
        wr(14, 8'h80);
        rd_expect(14, 8'h00, "R7 write 1 clears power-up");

        // R5/R3/R4 load time while halted
        wr(0, 8'h58); wr(1, 8'h59); wr(2, 8'h23); wr(3, 8'h31);
        wr(4, 8'h12); wr(5, 8'h99); wr(6, 8'h06);
        ticks(3);
        rd_expect(0, 8'h00, "R4 shadow unchanged before request");
        wr(13, 8'h40);
        rd_expect(0, 8'h58, "R3 frozen while halted");
        rd_expect(13, 8'h00, "R4 get-time bit reads 0");

        // R3 run, R2 full wrap
        wr(13, 8'h01);
        rd_expect(14, 8'h02, "R3 status run bit");
        rd_expect(13, 8'h01, "R3 control run bit");
        ticks(2);
        wr(13, 8'h41);
        rd_expect(0, 8'h00, "R2 seconds wrap");
        rd_expect(1, 8'h00, "R2 minutes wrap");
        rd_expect(2, 8'h00, "R2 hours wrap");
        rd_expect(3, 8'h01, "R2 day wrap");
        rd_expect(4, 8'h01, "R2 month wrap");
        rd_expect(5, 8'h00, "R2 year wrap");
        rd_expect(6, 8'h00, "R2 week wrap");
        rd_expect(14, 8'h3E, "R8 all event flags");
        ticks(1);
        rd_expect(0, 8'h00, "R4 shadow coherent");
        wr(13, 8'h41);
        rd_expect(0, 8'h01, "R4 snapshot refresh");

        // R11 leap handling
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
        wr(13, 8'h01); ticks(1); wr(13, 8'h41);
        rd_expect(3, 8'h29, "R11 leap day 29");
        rd_expect(4, 8'h02, "R11 leap month stays");
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
        wr(13, 8'h01); ticks(1); wr(13, 8'h41);
        rd_expect(3, 8'h01, "R11 non-leap day");
        rd_expect(4, 8'h03, "R11 non-leap month");
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h23);
        wr(13, 8'h01); ticks(1); wr(13, 8'h41);
        rd_expect(3, 8'h01, "R2 30-day month end");
        rd_expect(4, 8'h05, "R2 month advance");

        // R6/R9 alarm
        wr(14, 8'hFC);
        set_time(8'h10, 8'h20, 8'h05, 8'h15, 8'h06, 8'h30);
        wr(7, 8'h12); wr(8, 8'h20); wr(9, 8'h05);
        wr(10, 8'h15); wr(11, 8'h06); wr(12, 8'h30);
        wr(15, 8'h08);
        wr(13, 8'h01);
        ticks(1);
        irq_expect(1'b0, "R6 no alarm before match");
        rd_expect(14, 8'h06, "R6 status before match");
        ticks(1);
        irq_expect(1'b1, "R9 alarm irq");
        rd_expect(14, 8'h46, "R6 alarm flag set");
        ticks(1);
        irq_expect(1'b1, "R6 alarm sticky");
        wr(14, 8'h00);
        irq_expect(1'b1, "R7 write 0 keeps alarm");
        wr(14, 8'h40);
        irq_expect(1'b0, "R9 irq released");
        rd_expect(14, 8'h06, "R7 only alarm cleared");

        // R8/R9 periodic selection
        wr(15, 8'h05);
        wr(14, 8'hFC);
        set_time(8'h58, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
        wr(13, 8'h01);
        ticks(1);
        irq_expect(1'b0, "R9 second flag not selected");
        ticks(1);
        irq_expect(1'b1, "R8 minute rollover irq");
        wr(14, 8'h08);
        irq_expect(1'b0, "R9 minute flag cleared");
        wr(15, 8'h04);
        irq_expect(1'b1, "R9 select second flag");
        wr(14, 8'h04);
        irq_expect(1'b0, "R9 second flag cleared");

        // R5 storage and unmapped
        rd_expect(7, 8'h12, "R5 alarm readback");
        wr(16, 8'hA5); wr(17, 8'h3C);
        rd_expect(16, 8'hA5, "R5 storage low");
        rd_expect(17, 8'h3C, "R5 storage high");
        rd_expect(21, 8'h00, "R5 unmapped reads zero");
        rd_expect(15, 8'h04, "R5 enable readback");

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule